// File: doc/BRIEF.md
# Ethernet Frame to Mailbox Segmenter

This block takes whole Ethernet frames from a byte-wide valid/ready stream and forwards each one as a numbered sequence of mailbox message segments. The first six bytes of a frame hold the destination hardware address. That address is looked up in a small programmable table to pick the target mailbox. Before any segment leaves, the frame is held in full in an internal byte store, so its length is known. The frame is then cut into segments of `SEG_BYTES` bytes each. The last segment carries whatever remains.

Every segment goes out on a second valid/ready stream. With each segment the block sends the mailbox number, the total segment count and the segment's own index. Delivery is stop-and-wait. After the last byte of a segment is accepted, the block waits for an acknowledge carrying that index. If none arrives within `tmo_cycles` clock cycles, it sends the segment again. After three resends of the same segment, the message is abandoned. Once the final segment is acknowledged, a one-cycle doorbell names the mailbox. A new frame is accepted only after that doorbell, after an abandon, or after a frame is discarded.

Back-pressure works as follows:
- The input side transfers a byte on a clock edge where `in_valid` and `in_ready` are both high.
- The output side transfers a byte on a clock edge where `seg_valid` and `seg_ready` are both high.
- While `seg_ready` is low, all segment outputs hold their values.
- `SEG_BYTES` and `SEG_BYTES*MAX_SEGS` must be powers of two, and `SEG_BYTES*MAX_SEGS` must be at least 8.

Top module: `eth_seg_framer`

## Requirements
- R1: After reset, `in_ready` is 1, `seg_valid`, `bell_valid` and `abort_pulse` are 0, and `drop_count` is 0.
- R2: While a frame is being segmented or a doorbell is pending, `in_ready` is 0 and no input byte is taken. While `in_ready` is 1, `seg_valid` and `bell_valid` are 0.
- R3: The key is the first six bytes of the frame, with byte 0 as the most significant byte. It is compared against every table entry whose enable bit is 1, and the lowest-numbered matching entry supplies the mailbox. A table write takes effect on the edge where `cfg_we` is 1 and sets that entry's address, mailbox and enable.
- R4: A frame whose key matches no enabled entry is discarded. No segment and no doorbell are produced, `drop_count` is unchanged, and `in_ready` returns to 1.
- R5: Segment k carries frame bytes k*SEG_BYTES onward, in frame order. Every segment except the last has SEG_BYTES bytes, and the last has the remainder (1 to SEG_BYTES bytes). `seg_last` is 1 exactly on a segment's final byte.
- R6: `seg_count` equals ceil(length/SEG_BYTES) on every byte. `seg_index` starts at 0 and rises by one per new segment. `seg_index` is always below `seg_count`.
- R7: The next segment starts only after an acknowledge with `ack_index` equal to the current index. An acknowledge with any other index, or one given outside the wait, is ignored.
- R8: If no matching acknowledge arrives, the same segment is sent again from its first byte. Its first byte becomes valid `tmo_cycles` cycles after the edge that took the previous copy's last byte.
- R9: If the first copy and three resends of a segment all go unacknowledged, `abort_pulse` is 1 for one cycle. The message is then dropped with no doorbell, and `in_ready` returns to 1.
- R10: On the cycle after the last segment's acknowledge is taken, `bell_valid` is 1 for exactly one cycle, with `bell_mbox` equal to the message's mailbox.
- R11: A frame longer than SEG_BYTES*MAX_SEGS bytes is discarded with no segment, and `drop_count` rises by one. A frame of exactly that length is sent normally.
- R12: While `seg_valid` is 1 and `seg_ready` is 0, `seg_valid`, `seg_data`, `seg_index` and `seg_last` hold on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Block can take a frame byte |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of the frame |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_sel | input | clog2(ENTRIES) | Entry being written |
| cfg_en | input | 1 | Enable bit for the entry |
| cfg_mac | input | 48 | Hardware address for the entry |
| cfg_mbox | input | MBOX_W | Mailbox for the entry |
| tmo_cycles | input | TMO_W | Acknowledge wait in cycles (at least 1) |
| seg_valid | output | 1 | Segment byte valid |
| seg_ready | input | 1 | Sink takes the segment byte |
| seg_data | output | 8 | Segment byte |
| seg_last | output | 1 | Final byte of the segment |
| seg_mbox | output | MBOX_W | Target mailbox |
| seg_count | output | clog2(MAX_SEGS+1) | Segments in the message |
| seg_index | output | clog2(MAX_SEGS) | Index of this segment |
| ack_valid | input | 1 | Segment acknowledge |
| ack_index | input | clog2(MAX_SEGS) | Index being acknowledged |
| bell_valid | output | 1 | Completion doorbell, one cycle |
| bell_mbox | output | MBOX_W | Mailbox of the finished message |
| abort_pulse | output | 1 | Message abandoned, one cycle |
| drop_count | output | DROP_W | Oversized frames discarded, wrapping |

## Verification
The main path is driven with frames of several lengths, each checked byte by byte:
- A length that is an exact multiple of the segment size shows that no empty trailing segment appears.
- A length one byte past a multiple shows that a one-byte remainder segment is produced.
- A frame that exactly fills the store, and one a single byte larger, separate the accept and drop decisions at the capacity edge.

Frames addressed to different table entries, and to no entry, show that the mailbox really comes from the lookup. Rewriting a duplicate entry shows that the lowest index wins. Withholding acknowledges, or sending one with a wrong index, separates normal advance, timed resend and abandon. Stalling the sink mid-segment shows that outputs hold under back-pressure.

// File: rtl/seg_pkg.sv
package seg_pkg;

  typedef enum logic [2:0] {
    ST_RX    = 3'd0,
    ST_CHECK = 3'd1,
    ST_SEND  = 3'd2,
    ST_WAIT  = 3'd3,
    ST_BELL  = 3'd4
  } seg_state_e;

  localparam int KEY_BYTES = 6;
  localparam int RESEND_MAX = 3;

endpackage

// File: rtl/seg_mac_lookup.sv
module seg_mac_lookup #(
  parameter int ENTRIES = 8,
  parameter int MBOX_W = 4,
  localparam int SW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SW-1:0]     cfg_sel,
  input  logic              cfg_en,
  input  logic [47:0]       cfg_mac,
  input  logic [MBOX_W-1:0] cfg_mbox,
  input  logic [47:0]       key_mac,
  output logic              hit,
  output logic [MBOX_W-1:0] hit_mbox
);

  logic [ENTRIES-1:0]        match_v;
  logic [ENTRIES*MBOX_W-1:0] mbox_flat;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic              en_r;
    logic [47:0]       mac_r;
    logic [MBOX_W-1:0] mb_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_r  <= 1'b0;
        mac_r <= '0;
        mb_r  <= '0;
      end else if (cfg_we && cfg_sel == SW'(e)) begin
        en_r  <= cfg_en;
        mac_r <= cfg_mac;
        mb_r  <= cfg_mbox;
      end
    end

    assign match_v[e] = en_r && (mac_r == key_mac);
    assign mbox_flat[e*MBOX_W +: MBOX_W] = mb_r;
  end

  // lowest entry number wins: scan downward so the last assignment is the lowest
  always_comb begin
    hit      = 1'b0;
    hit_mbox = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (match_v[e]) begin
        hit      = 1'b1;
        hit_mbox = mbox_flat[e*MBOX_W +: MBOX_W];
      end
    end
  end

endmodule

// File: rtl/seg_byte_store.sv
module seg_byte_store #(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/seg_ctrl.sv
module seg_ctrl
  import seg_pkg::*;
#(
  parameter int SEG_BYTES = 64,
  parameter int MAX_SEGS = 16,
  parameter int MBOX_W = 4,
  parameter int TMO_W = 16,
  parameter int DROP_W = 8,
  localparam int CAP = SEG_BYTES * MAX_SEGS,
  localparam int LW = $clog2(CAP + 1),
  localparam int AW = $clog2(CAP),
  localparam int BW = $clog2(SEG_BYTES),
  localparam int IW = $clog2(MAX_SEGS),
  localparam int CW = $clog2(MAX_SEGS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic [47:0]       key_mac,
  input  logic              hit,
  input  logic [MBOX_W-1:0] hit_mbox,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [AW-1:0]     rd_addr,
  input  logic              seg_ready,
  output logic              seg_valid,
  output logic              seg_last,
  output logic [MBOX_W-1:0] seg_mbox,
  output logic [CW-1:0]     seg_count,
  output logic [IW-1:0]     seg_index,
  input  logic              ack_valid,
  input  logic [IW-1:0]     ack_index,
  input  logic [TMO_W-1:0]  tmo_cycles,
  output logic              bell_valid,
  output logic [MBOX_W-1:0] bell_mbox,
  output logic              abort_pulse,
  output logic [DROP_W-1:0] drop_count
);

  seg_state_e        state_q;
  logic [LW-1:0]     rx_cnt_q;
  logic              rx_ovf_q;
  logic [47:0]       mac_q;
  logic [LW-1:0]     len_q;
  logic [CW-1:0]     nseg_q;
  logic [MBOX_W-1:0] mbox_q;
  logic [IW-1:0]     seg_q;
  logic [BW-1:0]     off_q;
  logic [TMO_W-1:0]  tcnt_q;
  logic [1:0]        retry_q;
  logic              abort_q;
  logic [DROP_W-1:0] drop_q;

  logic [LW:0]       len_round;
  logic [CW-1:0]     nseg_calc;
  logic              is_final;
  logic [LW-1:0]     seg_base;
  logic [LW-1:0]     seg_rem;
  logic [BW-1:0]     end_off;
  logic              at_end;
  logic              ack_hit;
  logic              tmo_hit;
  logic              rx_full;

  assign len_round = {1'b0, len_q} + (LW + 1)'(SEG_BYTES - 1);
  assign nseg_calc = CW'(len_round >> BW);
  assign is_final  = (CW'(seg_q) + CW'(1)) == nseg_q;
  assign seg_base  = LW'(seg_q) << BW;
  assign seg_rem   = len_q - seg_base;
  assign end_off   = is_final ? BW'(seg_rem - LW'(1)) : BW'(SEG_BYTES - 1);
  assign at_end    = (off_q == end_off);
  assign ack_hit   = ack_valid && (ack_index == seg_q);
  assign tmo_hit   = (tcnt_q == tmo_cycles - TMO_W'(1));
  assign rx_full   = (rx_cnt_q == LW'(CAP));

  assign in_ready    = (state_q == ST_RX);
  assign key_mac     = mac_q;
  assign wr_en       = (state_q == ST_RX) && in_valid && !rx_full;
  assign wr_addr     = rx_cnt_q[AW-1:0];
  assign rd_addr     = AW'(seg_base + LW'(off_q));
  assign seg_valid   = (state_q == ST_SEND);
  assign seg_last    = at_end;
  assign seg_mbox    = mbox_q;
  assign seg_count   = nseg_q;
  assign seg_index   = seg_q;
  assign bell_valid  = (state_q == ST_BELL);
  assign bell_mbox   = mbox_q;
  assign abort_pulse = abort_q;
  assign drop_count  = drop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_RX;
      rx_cnt_q <= '0;
      rx_ovf_q <= 1'b0;
      mac_q    <= '0;
      len_q    <= '0;
      nseg_q   <= '0;
      mbox_q   <= '0;
      seg_q    <= '0;
      off_q    <= '0;
      tcnt_q   <= '0;
      retry_q  <= '0;
      abort_q  <= 1'b0;
      drop_q   <= '0;
    end else begin
      abort_q <= 1'b0;
      case (state_q)
        ST_RX: begin
          if (in_valid) begin
            if (rx_cnt_q < LW'(KEY_BYTES)) mac_q <= {mac_q[39:0], in_data};
            if (rx_full) rx_ovf_q <= 1'b1;
            else         rx_cnt_q <= rx_cnt_q + LW'(1);
            if (in_last) begin
              rx_cnt_q <= '0;
              rx_ovf_q <= 1'b0;
              if (rx_ovf_q || rx_full) begin
                drop_q <= drop_q + DROP_W'(1);
              end else begin
                len_q   <= rx_cnt_q + LW'(1);
                state_q <= ST_CHECK;
              end
            end
          end
        end
        ST_CHECK: begin
          if (hit) begin
            mbox_q  <= hit_mbox;
            nseg_q  <= nseg_calc;
            seg_q   <= '0;
            off_q   <= '0;
            retry_q <= '0;
            state_q <= ST_SEND;
          end else begin
            state_q <= ST_RX;
          end
        end
        ST_SEND: begin
          if (seg_ready) begin
            if (at_end) begin
              tcnt_q  <= '0;
              state_q <= ST_WAIT;
            end else begin
              off_q <= off_q + BW'(1);
            end
          end
        end
        ST_WAIT: begin
          if (ack_hit) begin
            if (is_final) begin
              state_q <= ST_BELL;
            end else begin
              seg_q   <= seg_q + IW'(1);
              off_q   <= '0;
              retry_q <= '0;
              state_q <= ST_SEND;
            end
          end else if (tmo_hit) begin
            if (retry_q == 2'(RESEND_MAX)) begin
              abort_q <= 1'b1;
              state_q <= ST_RX;
            end else begin
              retry_q <= retry_q + 2'd1;
              off_q   <= '0;
              state_q <= ST_SEND;
            end
          end else begin
            tcnt_q <= tcnt_q + TMO_W'(1);
          end
        end
        ST_BELL: state_q <= ST_RX;
        default: state_q <= ST_RX;
      endcase
    end
  end

endmodule

// File: rtl/eth_seg_framer.sv
module eth_seg_framer #(
  parameter int SEG_BYTES = 64,
  parameter int MAX_SEGS = 16,
  parameter int ENTRIES = 8,
  parameter int MBOX_W = 4,
  parameter int TMO_W = 16,
  parameter int DROP_W = 8,
  localparam int SW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int IW = $clog2(MAX_SEGS),
  localparam int CW = $clog2(MAX_SEGS + 1),
  localparam int CAP = SEG_BYTES * MAX_SEGS,
  localparam int AW = $clog2(CAP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              cfg_we,
  input  logic [SW-1:0]     cfg_sel,
  input  logic              cfg_en,
  input  logic [47:0]       cfg_mac,
  input  logic [MBOX_W-1:0] cfg_mbox,
  input  logic [TMO_W-1:0]  tmo_cycles,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [7:0]        seg_data,
  output logic              seg_last,
  output logic [MBOX_W-1:0] seg_mbox,
  output logic [CW-1:0]     seg_count,
  output logic [IW-1:0]     seg_index,
  input  logic              ack_valid,
  input  logic [IW-1:0]     ack_index,
  output logic              bell_valid,
  output logic [MBOX_W-1:0] bell_mbox,
  output logic              abort_pulse,
  output logic [DROP_W-1:0] drop_count
);

  logic [47:0]       key_mac;
  logic              hit;
  logic [MBOX_W-1:0] hit_mbox;
  logic              wr_en;
  logic [AW-1:0]     wr_addr;
  logic [AW-1:0]     rd_addr;

  seg_mac_lookup #(.ENTRIES(ENTRIES), .MBOX_W(MBOX_W)) u_lookup (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_en(cfg_en),
    .cfg_mac(cfg_mac), .cfg_mbox(cfg_mbox),
    .key_mac(key_mac), .hit(hit), .hit_mbox(hit_mbox)
  );

  seg_byte_store #(.DEPTH(CAP)) u_store (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(in_data),
    .raddr(rd_addr), .rdata(seg_data)
  );

  seg_ctrl #(
    .SEG_BYTES(SEG_BYTES), .MAX_SEGS(MAX_SEGS), .MBOX_W(MBOX_W),
    .TMO_W(TMO_W), .DROP_W(DROP_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .key_mac(key_mac), .hit(hit), .hit_mbox(hit_mbox),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_addr(rd_addr),
    .seg_ready(seg_ready), .seg_valid(seg_valid), .seg_last(seg_last),
    .seg_mbox(seg_mbox), .seg_count(seg_count), .seg_index(seg_index),
    .ack_valid(ack_valid), .ack_index(ack_index), .tmo_cycles(tmo_cycles),
    .bell_valid(bell_valid), .bell_mbox(bell_mbox),
    .abort_pulse(abort_pulse), .drop_count(drop_count)
  );

endmodule

// File: rtl/eth_seg_framer_chk.sv
module eth_seg_framer_chk #(
  parameter int IW = 4,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          seg_valid,
  input logic          seg_ready,
  input logic [7:0]    seg_data,
  input logic          seg_last,
  input logic [IW-1:0] seg_index,
  input logic [CW-1:0] seg_count,
  input logic          bell_valid,
  input logic          abort_pulse
);

  // R12
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_data) &&
                                   $stable(seg_index) && $stable(seg_last)));

  // R6
  index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (CW'(seg_index) < seg_count));

  // R10
  bell_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bell_valid |=> !bell_valid);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!seg_valid && !bell_valid));

  // R9
  abort_no_bell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> (!bell_valid && in_ready));

endmodule

bind eth_seg_framer eth_seg_framer_chk #(.IW(IW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_data(seg_data),
  .seg_last(seg_last), .seg_index(seg_index), .seg_count(seg_count),
  .bell_valid(bell_valid), .abort_pulse(abort_pulse)
);

// File: tb/sim_eth_seg_framer.sv
`timescale 1ns/100ps
module sim_eth_seg_framer;

  localparam int S = 4;
  localparam int NS = 4;
  localparam int CAPB = S * NS;
  localparam int TMO = 10;
  localparam logic [47:0] MAC_A = 48'h02_11_22_33_44_55;
  localparam logic [47:0] MAC_B = 48'h02_AA_BB_CC_DD_EE;
  localparam logic [47:0] MAC_C = 48'h02_00_00_00_00_99;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready;
  logic cfg_we = 1'b0, cfg_en = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [47:0] cfg_mac = '0;
  logic [3:0] cfg_mbox = '0;
  logic [15:0] tmo_cycles = 16'(TMO);
  logic seg_valid, seg_last;
  logic seg_ready = 1'b0;
  logic [7:0] seg_data;
  logic [3:0] seg_mbox, bell_mbox;
  logic [2:0] seg_count;
  logic [1:0] seg_index;
  logic ack_valid = 1'b0;
  logic [1:0] ack_index = '0;
  logic bell_valid, abort_pulse;
  logic [7:0] drop_count;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  eth_seg_framer #(
    .SEG_BYTES(S), .MAX_SEGS(NS), .ENTRIES(4), .MBOX_W(4), .TMO_W(16), .DROP_W(8)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_en(cfg_en), .cfg_mac(cfg_mac), .cfg_mbox(cfg_mbox), .tmo_cycles(tmo_cycles),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_data(seg_data),
    .seg_last(seg_last), .seg_mbox(seg_mbox), .seg_count(seg_count),
    .seg_index(seg_index), .ack_valid(ack_valid), .ack_index(ack_index),
    .bell_valid(bell_valid), .bell_mbox(bell_mbox), .abort_pulse(abort_pulse),
    .drop_count(drop_count)
  );

  // length, key select (0 = A -> mbox 5, 1 = B -> mbox 9, 2 = unknown)
  localparam int VEC [8][2] = '{'{6, 0}, '{9, 1}, '{16, 0}, '{17, 0},
                                '{8, 2}, '{13, 1}, '{7, 0}, '{11, 1}};

  function automatic logic [47:0] mac_of(int sel);
    return (sel == 0) ? MAC_A : (sel == 1) ? MAC_B : MAC_C;
  endfunction

  function automatic logic [7:0] byte_of(logic [47:0] mac, int len, int i);
    if (i < 6) return mac[47 - 8*i -: 8];
    return 8'((i * 7 + len) & 8'hFF);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input int sel, input bit en, input logic [47:0] mac, input int mb);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_en = en; cfg_mac = mac; cfg_mbox = 4'(mb);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_frame(input logic [47:0] mac, input int len);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_data = byte_of(mac, len, i);
      in_last = (i == len - 1);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last = 1'b0;
  endtask

  task automatic take_byte(input logic [7:0] ed, input int eidx, input int ecnt,
                           input bit elast, input int emb, input bit stall);
    int g = 0;
    bit ok;
    while (!seg_valid && g < 200) begin
      @(negedge clk);
      g++;
    end
    if (stall) begin
      @(negedge clk);
      @(negedge clk);
      // R12: byte held while the sink stalls
      chk(seg_valid && seg_data == ed, "R12 held byte", int'(seg_data), int'(ed));
    end
    ok = seg_valid && seg_data == ed && int'(seg_index) == eidx &&
         int'(seg_count) == ecnt && seg_last == elast && int'(seg_mbox) == emb;
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R5/R6 v=%0b data=%0h/%0h idx=%0d/%0d cnt=%0d/%0d last=%0b/%0b mbox=%0d/%0d",
               seg_valid, seg_data, ed, seg_index, eidx, seg_count, ecnt,
               seg_last, elast, seg_mbox, emb);
    end
    seg_ready = 1'b1;
    @(posedge clk);
    #1 seg_ready = 1'b0;
  endtask

  task automatic recv_seg(input logic [47:0] mac, input int len, input int s,
                          input int emb, input bit stall);
    int nseg = (len + S - 1) / S;
    int sl = (s < nseg - 1) ? S : len - s * S;
    for (int b = 0; b < sl; b++)
      take_byte(byte_of(mac, len, s * S + b), s, nseg, b == sl - 1, emb, stall && b == 1);
  endtask

  task automatic ack(input int s);
    @(negedge clk);
    ack_valid = 1'b1;
    ack_index = 2'(s);
    @(posedge clk);
    #1 ack_valid = 1'b0;
  endtask

  task automatic recv_msg(input logic [47:0] mac, input int len, input int emb, input bit stall);
    int nseg = (len + S - 1) / S;
    for (int s = 0; s < nseg; s++) begin
      recv_seg(mac, len, s, emb, stall);
      ack(s);
    end
    // R10: doorbell the cycle after the final acknowledge
    chk(bell_valid && int'(bell_mbox) == emb, "R10 doorbell mbox", int'(bell_mbox), emb);
    @(posedge clk);
    #1 chk(!bell_valid, "R10 doorbell single cycle", int'(bell_valid), 0);
  endtask

  task automatic expect_quiet(input int n, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (seg_valid || bell_valid) seen = 1'b1;
    end
    chk(!seen && in_ready, tag, int'(seen), 0);
  endtask

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d0;
    int n;
    bit ab, stray;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(in_ready && !seg_valid && !bell_valid && !abort_pulse && drop_count == 0,
        "R1 reset outputs", int'({in_ready, seg_valid, bell_valid, abort_pulse}), 8);
    rst_n = 1'b1;
    cfg(0, 1'b1, MAC_A, 5);
    cfg(1, 1'b1, MAC_B, 9);

    // table walk: R3 R4 R5 R6 R11
    for (int v = 0; v < 8; v++) begin
      d0 = int'(drop_count);
      send_frame(mac_of(VEC[v][1]), VEC[v][0]);
      if (VEC[v][0] > CAPB) begin
        chk(int'(drop_count) == d0 + 1, "R11 oversize counted", int'(drop_count), d0 + 1);
        expect_quiet(20, "R11 oversize no segment");
      end else if (VEC[v][1] == 2) begin
        expect_quiet(20, "R4 unknown key discarded");
        chk(int'(drop_count) == d0, "R4 drop count unchanged", int'(drop_count), d0);
      end else begin
        // R2: input closed while the message is in flight
        chk(!in_ready, "R2 input closed", int'(in_ready), 0);
        recv_msg(mac_of(VEC[v][1]), VEC[v][0], (VEC[v][1] == 0) ? 5 : 9, v[0]);
        chk(in_ready, "R2 input reopened", int'(in_ready), 1);
      end
    end

    // R3: duplicate entry, lowest index wins; disabling it exposes the next
    cfg(2, 1'b1, MAC_A, 7);
    send_frame(MAC_A, 6);
    recv_msg(MAC_A, 6, 5, 1'b0);
    cfg(0, 1'b0, MAC_A, 5);
    send_frame(MAC_A, 6);
    recv_msg(MAC_A, 6, 7, 1'b0);
    cfg(0, 1'b1, MAC_A, 5);

    // R7 R8: wrong acknowledge ignored, timed resend of segment 0
    send_frame(MAC_A, 6);
    recv_seg(MAC_A, 6, 0, 5, 1'b0);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      ack_valid = (n == 2);
      ack_index = 2'd1;
    end while (!seg_valid && n < 100);
    ack_valid = 1'b0;
    chk(n == TMO + 1, "R8 resend delay", n, TMO + 1);
    chk(seg_index == 2'd0, "R7 wrong ack ignored", int'(seg_index), 0);
    recv_seg(MAC_A, 6, 0, 5, 1'b0);
    ack(0);
    recv_seg(MAC_A, 6, 1, 5, 1'b0);
    ack(1);
    chk(bell_valid && bell_mbox == 4'd5, "R10 doorbell after resend", int'(bell_mbox), 5);

    // R9: no acknowledge at all -> first copy plus three resends, then abandon
    send_frame(MAC_B, 7);
    for (int k = 0; k < 4; k++) recv_seg(MAC_B, 7, 0, 9, 1'b0);
    ab = 1'b0;
    stray = 1'b0;
    for (int i = 0; i < 3 * TMO; i++) begin
      @(negedge clk);
      if (abort_pulse) ab = 1'b1;
      if (seg_valid || bell_valid) stray = 1'b1;
    end
    chk(ab, "R9 abort pulse", int'(ab), 1);
    chk(!stray, "R9 no further segment or doorbell", int'(stray), 0);
    chk(in_ready, "R9 input reopened", int'(in_ready), 1);

    // R11 boundary again after errors: exact capacity still sent
    send_frame(MAC_B, CAPB);
    recv_msg(MAC_B, CAPB, 9, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule